// File: doc/BRIEF.md
# Dual-Format Serial Audio Receiver

This block takes stereo PCM audio from a three-wire serial link (bit clock, word clock, serial data) and turns it into parallel left and right samples of 18 bits. The bit clock is the block's own clock. On every rising edge the block samples the word clock and the data line together. A static format input picks one of two framings. In the right-justified framing the word ends on the last bit before the word-clock change. In the I2S-style framing the word starts one bit after the word-clock change.

The block also counts the bit clocks in each frame. When a frame holds exactly 32 of them, it treats both channels as packed 16-bit words. Each packed word fills a whole word-clock half, and the 16 bits go into the top of the 18-bit result. In the I2S framing, shorter words are padded with zeros and longer words lose their trailing bits.

When a frame has ended, the block presents one left/right pair together with a single-cycle valid strobe and a flag that reports whether the frame was packed.

Top module: `dual_fmt_audio_rx`

## Requirements
- R1: With the format input low (right-justified), the left channel is the word-clock-high half and the right channel is the word-clock-low half. Each result is the last 18 bits sampled before the word clock changes level, MSB first. A frame ends when the word clock rises.
- R2: In the right-justified framing, any bits that arrive in a half-frame before its final 18 bits have no effect on the result.
- R3: When a frame contains exactly 32 bit clocks, the packed flag output is 1 for that frame. In the right-justified framing each channel is then the last 16 bits of its half, placed in bits 17:2 with bits 1:0 set to zero.
- R4: With the format input high (I2S), the left channel is the word-clock-low half and the right channel is the word-clock-high half. The MSB is the bit sampled on the second rising edge after the word-clock change, and the following bits fill downward. A frame ends when the word clock falls.
- R5: In the I2S framing, a word shorter than 18 bits fills the top of the result, and the unfilled low bits are zero.
- R6: In the I2S framing, a word longer than 18 bits keeps its first 18 bits, and the trailing bits are discarded.
- R7: The valid output is a single-cycle pulse, once per frame. It appears in the cycle after the rising edge that first samples the word-clock level that opens the next frame. The sample and packed-flag outputs change only together with this pulse.
- R8: After reset all outputs are zero. No valid pulse is raised until a full frame has been seen between two frame boundaries that follow reset.
- R9: The bit count is measured for every frame. A change between 32 and any other count takes effect in the packed flag and in the alignment of the very frame that changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; all logic runs on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ws_i | input | 1 | Word clock selecting the channel half |
| sd_i | input | 1 | Serial data, MSB first |
| fmt_i2s_i | input | 1 | Framing select: 0 right-justified, 1 I2S |
| left_o | output | 18 | Left sample of the last completed frame |
| right_o | output | 18 | Right sample of the last completed frame |
| pair_valid_o | output | 1 | One-cycle strobe when a new pair is presented |
| packed_o | output | 1 | Packed 16-bit framing detected for the presented frame |

## Verification
A frame only finishes when the word-clock level that opens the next frame is sampled, so each sample pair, the packed flag and the valid strobe are due exactly one bit clock after that slot is driven. The bench drives each slot on a falling edge. On that same falling edge it first compares what the previous rising edge produced: when a frame boundary was driven in the previous slot, it expects the pair there; in every other slot it expects the strobe to be low. Junk leading bits, short and long I2S words, and frames that switch between 32 and other bit counts are laid into these same slot-exact streams. Each format starts after reset with an idle half, so the first boundary is a real word-clock change.

// File: rtl/sra_pkg.sv
package sra_pkg;

  typedef enum logic {
    FMT_RJ  = 1'b0,
    FMT_I2S = 1'b1
  } fmt_e;

  // word-clock events seen on one bit-clock rising edge
  typedef struct packed {
    logic trans;       // level differs from previous sample
    logic frame_edge;  // level opening a new frame
    logic mid_edge;    // level opening the second half
  } ws_evt_t;

endpackage

// File: rtl/sra_ws_tracker.sv
module sra_ws_tracker
  import sra_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    ws,
  input  fmt_e    fmt,
  output ws_evt_t evt,
  output logic    armed
);

  logic ws_prev;
  logic ws_seen;
  logic open_lvl;

  // the frame opens with word clock high for right-justified, low for I2S
  assign open_lvl = (fmt == FMT_RJ);

  always_comb begin
    evt.trans      = ws_seen && (ws != ws_prev);
    evt.frame_edge = evt.trans && (ws == open_lvl);
    evt.mid_edge   = evt.trans && (ws != open_lvl);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ws_prev <= 1'b0;
      ws_seen <= 1'b0;
      armed   <= 1'b0;
    end else begin
      ws_prev <= ws;
      ws_seen <= 1'b1;
      if (evt.frame_edge) armed <= 1'b1;
    end
  end

endmodule

// File: rtl/sra_rj_capture.sv
module sra_rj_capture #(
  parameter int SAMPLE_W = 18
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sd,
  output logic [SAMPLE_W-1:0] tail
);

  logic [SAMPLE_W-1:0] sh;

  // continuous shift: only the most recent SAMPLE_W bits survive
  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[SAMPLE_W-2:0], sd};
  end

  assign tail = sh;

endmodule

// File: rtl/sra_i2s_capture.sv
module sra_i2s_capture #(
  parameter int SAMPLE_W = 18,
  localparam int POS_W   = $clog2(SAMPLE_W + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sd,
  input  logic                trans,
  output logic [SAMPLE_W-1:0] word
);

  logic [SAMPLE_W-1:0] cap;
  logic [POS_W-1:0]    pos;

  // current bit merged into the word at its MSB-first position
  always_comb begin
    word = cap;
    for (int i = 0; i < SAMPLE_W; i++) begin
      if (pos == POS_W'(SAMPLE_W - 1 - i)) word[i] = sd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap <= '0;
      pos <= '0;
    end else if (trans) begin
      cap <= '0;
      pos <= '0;
    end else begin
      cap <= word;
      if (pos != POS_W'(SAMPLE_W)) pos <= pos + 1'b1;
    end
  end

  // R5
  short_pad_chk: assert property (@(posedge clk) disable iff (rst)
    (pos <= POS_W'(SAMPLE_W - 2)) |-> (cap[1:0] == 2'b00));

endmodule

// File: rtl/sra_frame_meter.sv
module sra_frame_meter #(
  parameter int CNT_W      = 8,
  parameter int PACK_BCLKS = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_edge,
  output logic packed_now
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                  cnt <= '0;
    else if (frame_edge)      cnt <= CNT_W'(1);
    else if (cnt != '1)       cnt <= cnt + 1'b1;
  end

  // at a frame edge cnt holds the bit clocks of the frame just closed
  assign packed_now = (cnt == CNT_W'(PACK_BCLKS));

endmodule

// File: rtl/dual_fmt_audio_rx.sv
module dual_fmt_audio_rx #(
  parameter int SAMPLE_W   = 18,
  parameter int PACK_W     = 16,
  parameter int PACK_BCLKS = 32,
  parameter int CNT_W      = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ws_i,
  input  logic                sd_i,
  input  logic                fmt_i2s_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                pair_valid_o,
  output logic                packed_o
);
  import sra_pkg::*;

  localparam int PAD_W = SAMPLE_W - PACK_W;

  fmt_e                fmt;
  ws_evt_t             evt;
  logic                armed;
  logic                packed_now;
  logic [SAMPLE_W-1:0] rj_tail;
  logic [SAMPLE_W-1:0] i2s_word;
  logic [SAMPLE_W-1:0] cur_word;
  logic [SAMPLE_W-1:0] left_hold;
  logic [SAMPLE_W-1:0] left_pk;
  logic [SAMPLE_W-1:0] right_pk;
  logic                use_pack;

  assign fmt = fmt_e'(fmt_i2s_i);

  sra_ws_tracker u_ws (
    .clk   (clk),
    .rst   (rst),
    .ws    (ws_i),
    .fmt   (fmt),
    .evt   (evt),
    .armed (armed)
  );

  sra_rj_capture #(.SAMPLE_W(SAMPLE_W)) u_rj (
    .clk  (clk),
    .rst  (rst),
    .sd   (sd_i),
    .tail (rj_tail)
  );

  sra_i2s_capture #(.SAMPLE_W(SAMPLE_W)) u_i2s (
    .clk   (clk),
    .rst   (rst),
    .sd    (sd_i),
    .trans (evt.trans),
    .word  (i2s_word)
  );

  sra_frame_meter #(.CNT_W(CNT_W), .PACK_BCLKS(PACK_BCLKS)) u_meter (
    .clk        (clk),
    .rst        (rst),
    .frame_edge (evt.frame_edge),
    .packed_now (packed_now)
  );

  assign cur_word = (fmt == FMT_I2S) ? i2s_word : rj_tail;
  assign use_pack = (fmt == FMT_RJ) && packed_now;

  // packed words occupy the top of the sample; pad width picks the variant
  generate
    if (PAD_W > 0) begin : g_pad
      assign left_pk  = {left_hold[PACK_W-1:0], {PAD_W{1'b0}}};
      assign right_pk = {cur_word[PACK_W-1:0],  {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign left_pk  = left_hold;
      assign right_pk = cur_word;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      left_hold <= '0;
    end else if (evt.mid_edge) begin
      left_hold <= cur_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      left_o       <= '0;
      right_o      <= '0;
      pair_valid_o <= 1'b0;
      packed_o     <= 1'b0;
    end else begin
      pair_valid_o <= 1'b0;
      if (evt.frame_edge && armed) begin
        pair_valid_o <= 1'b1;
        packed_o     <= packed_now;
        left_o       <= use_pack ? left_pk  : left_hold;
        right_o      <= use_pack ? right_pk : cur_word;
      end
    end
  end

  // R7
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    pair_valid_o |=> !pair_valid_o);

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !pair_valid_o |-> ($stable(left_o) && $stable(right_o) && $stable(packed_o)));

  // R3
  packed_lsb_chk: assert property (@(posedge clk) disable iff (rst)
    (pair_valid_o && packed_o && !fmt_i2s_i && $stable(fmt_i2s_i))
      |-> (left_o[1:0] == 2'b00 && right_o[1:0] == 2'b00));

  // R8
  armed_first_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pair_valid_o) |-> $past(armed));

endmodule

// File: tb/dual_fmt_audio_rx_tb.sv
module dual_fmt_audio_rx_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ws  = 1'b0;
  logic        sd  = 1'b0;
  logic        fmt = 1'b0;
  logic [17:0] left_o, right_o;
  logic        pair_valid_o, packed_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  logic        carry = 1'b0;
  logic        pend = 1'b0, have_prev = 1'b0;
  logic [17:0] pend_l, pend_r, done_l, done_r;
  logic        pend_p, done_p;
  string       pend_tag, done_tag;

  always #5 clk = ~clk;

  dual_fmt_audio_rx u_dut (
    .clk          (clk),
    .rst          (rst),
    .ws_i         (ws),
    .sd_i         (sd),
    .fmt_i2s_i    (fmt),
    .left_o       (left_o),
    .right_o      (right_o),
    .pair_valid_o (pair_valid_o),
    .packed_o     (packed_o)
  );

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL R7 watchdog expired act=%0d exp<=150000", cyc);
      report();
      $finish;
    end
  end

  task automatic chk18(string msg, logic [17:0] act, logic [17:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", msg, act, exp);
    end
  endtask

  task automatic chk1(string msg, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%b exp=%b", msg, act, exp);
    end
  endtask

  function automatic logic [17:0] i2s_exp(logic [31:0] w, int n);
    logic [31:0] t;
    if (n >= 18) t = w >> (n - 18);
    else         t = w << (18 - n);
    return t[17:0];
  endfunction

  // compare what the previous rising edge produced, then drive the next slot
  task automatic drive_slot(logic lvl, logic d, logic start);
    @(negedge clk);
    if (pend) begin
      chk1("R7 pair_valid one cycle after frame boundary", pair_valid_o, 1'b1);
      chk18({pend_tag, " left sample"},  left_o,  pend_l);
      chk18({pend_tag, " right sample"}, right_o, pend_r);
      chk1("R3 R9 packed flag", packed_o, pend_p);
    end else begin
      chk1("R8 R7 no pair_valid away from frame end", pair_valid_o, 1'b0);
    end
    pend = 1'b0;
    ws = lvl;
    sd = d;
    if (start && have_prev) begin
      pend     = 1'b1;
      pend_l   = done_l;
      pend_r   = done_r;
      pend_p   = done_p;
      pend_tag = done_tag;
    end
  endtask

  task automatic send_phase(logic lvl, int p, int n, logic [31:0] w, logic start);
    for (int k = 0; k < p; k++) begin
      logic d;
      if (!fmt)        d = w[p - 1 - k];
      else if (k == 0) d = carry;
      else if (k <= n) d = w[n - k];
      else             d = 1'b0;
      drive_slot(lvl, d, start && (k == 0));
    end
    carry = (fmt && n == p) ? w[0] : 1'b0;
  endtask

  task automatic send_frame(int p, int nl, int nr, logic [31:0] wl, logic [31:0] wr, string tag);
    logic open_lvl;
    logic pk;
    open_lvl = ~fmt;
    send_phase(open_lvl, p, nl, wl, 1'b1);
    send_phase(~open_lvl, p, nr, wr, 1'b0);
    pk = (2 * p == 32);
    if (!fmt) begin
      done_l = pk ? {wl[15:0], 2'b00} : wl[17:0];
      done_r = pk ? {wr[15:0], 2'b00} : wr[17:0];
    end else begin
      done_l = i2s_exp(wl, nl);
      done_r = i2s_exp(wr, nr);
    end
    done_p    = pk;
    done_tag  = tag;
    have_prev = 1'b1;
  endtask

  task automatic end_seq();
    drive_slot(~fmt, carry, 1'b1);
    carry = 1'b0;
    drive_slot(~fmt, 1'b0, 1'b0);
    drive_slot(~fmt, 1'b0, 1'b0);
  endtask

  task automatic do_reset(logic f);
    @(negedge clk);
    rst = 1'b1;
    fmt = f;
    ws  = f;
    sd  = 1'b0;
    have_prev = 1'b0;
    pend  = 1'b0;
    carry = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk18("R8 reset left",  left_o,  18'h0);
    chk18("R8 reset right", right_o, 18'h0);
    chk1("R8 reset valid",  pair_valid_o, 1'b0);
    chk1("R8 reset packed", packed_o, 1'b0);
    for (int i = 0; i < 4; i++) drive_slot(f, 1'b0, 1'b0);
  endtask

  initial begin
    int plist[5];
    plist = '{16, 18, 20, 24, 32};
    void'($urandom(32'd7321));

    // right-justified framing
    do_reset(1'b0);
    send_frame(18, 0, 0, 32'h2A5C3, 32'h15A3C, "R1");
    send_frame(24, 0, 0, 32'hFF_1234, 32'hA5_3FFFF, "R2");
    send_frame(16, 0, 0, 32'hBEEF, 32'h1234, "R3");
    send_frame(18, 0, 0, 32'h3FFFF, 32'h00001, "R9");
    send_frame(16, 0, 0, 32'h8001, 32'h7FFE, "R9");
    send_frame(32, 0, 0, 32'hDEAD_BEEF, 32'h0F0F_0F0F, "R2");
    for (int f = 0; f < 40; f++) begin
      int p;
      p = plist[$urandom % 5];
      send_frame(p, 0, 0, $urandom, $urandom, "R1");
    end
    end_seq();

    // I2S framing
    do_reset(1'b1);
    send_frame(20, 18, 18, 32'h2A5C3, 32'h15A3C, "R4");
    send_frame(20, 16, 16, 32'hBEEF, 32'h8001, "R5");
    send_frame(24, 20, 20, 32'hFFFFD, 32'h12345, "R6");
    send_frame(16, 16, 16, 32'hCAFE, 32'h0101, "R5");
    send_frame(18, 18, 18, 32'h3FFFF, 32'h20001, "R4");
    for (int f = 0; f < 40; f++) begin
      int n, p;
      n = 16 + 2 * ($urandom % 3);
      if (n == 16 && ($urandom % 3) == 0) p = 16;
      else p = n + 1 + ($urandom % (32 - n));
      send_frame(p, n, n, $urandom, $urandom, (n > 18) ? "R6" : "R4");
    end
    end_seq();

    report();
    $finish;
  end

endmodule